// File: doc/BRIEF.md
# Bulk Erase Sequencer

This block drives the full electrical erase procedure of a bulk-erase flash array from the host side of a simple byte bus. A one-cycle `start` launches the flow. The sequencer first writes 00h to every byte of the array, with a fixed settling gap after each write. It then arms and fires a whole-chip erase with two back-to-back 20h command writes and holds off for a programmable number of clock cycles. After that it walks the array in ascending order. For each byte it writes the A0h margin-check command with the byte address, and on the next cycle reads that byte back.

A byte that reads FFh is erased, and the walk moves on. A byte that reads anything else triggers a new whole-chip erase. The walk then continues from that same byte, because the bytes already checked stay erased under further pulses. The number of erase pulses per run is capped. When the cap is used up on a failing byte, the sequencer raises `fail` and parks. After the last byte passes, it writes an exit command to leave margin-check mode and pulses `done`.

Top module: `bulk_erase_seq`

## Requirements
- R1: While reset is held, and on the first cycle after release, `busy`, `done`, `fail`, `fl_wr_en` and `fl_rd_en` are all low.
- R2: After `start`, the block writes data 00h to addresses 0 through DEPTH-1 in ascending order. Each such write is followed by exactly max(PROG_WAIT,1) cycles with no bus write.
- R3: After the last 00h write and its wait, the block writes 20h to address 0 on two consecutive cycles. Every re-erase uses the same two-cycle pair.
- R4: Between the second 20h write and the next A0h write there are exactly max(P,1) cycles with no write. P is the `pulse_cycles` value sampled on the `start` cycle; later changes to the input have no effect on that run.
- R5: Each byte check is an A0h write carrying the byte address, followed on the next cycle by `fl_rd_en` with the same address. A byte passes only when `fl_rd_data` is FFh on the cycle after the read strobe. After a pass, the next A0h write carries the address plus one.
- R6: When a byte fails, the block issues a new 20h/20h pair. The first A0h write after it carries the failing address.
- R7: After byte DEPTH-1 passes, the block writes EXIT_CMD (default 00h) to address 0. `done` is high for exactly one cycle, on the cycle after that write, and `busy` is low from then on.
- R8: If a byte fails after MAX_PULSES erase pulses in the run, `fail` rises, `busy` drops, and no further bus access occurs. `fail` stays high until the next `start`, which clears it and begins a new run.
- R9: A `start` pulse while `busy` is high is ignored: no second pre-program pass and no change to the running flow.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle `done` or `fail` appears. At most one of `busy`, `done` and `fail` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the erase flow |
| pulse_cycles | input | PULSE_W | Erase pulse length in clock cycles, sampled at start |
| fl_wr_en | output | 1 | Flash write strobe |
| fl_wr_addr | output | AW | Flash write address |
| fl_wr_data | output | 8 | Flash write data or command byte |
| fl_rd_en | output | 1 | Flash read strobe |
| fl_rd_addr | output | AW | Flash read address |
| fl_rd_data | input | 8 | Read data, valid the cycle after fl_rd_en |
| busy | output | 1 | Flow in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | Erase pulse budget exhausted, held until next start |

## Verification
The hardest situation to reach from the ports is a byte that fails verification deep in the array, and especially the last byte or a byte that never erases within the pulse budget. That situation only arises after a complete pre-program pass, one or more erase pulses and a partial walk. The bench gives its flash model a per-byte count of pulses needed before the byte reads FFh. It draws these counts at random and also sets them directly: a stubborn last byte, a byte above the budget, and all bytes erasing on the first pulse. In this way resume, retry and give-up paths are reached on demand, and the pulse and check counts can be predicted.

// File: rtl/bes_pkg.sv
package bes_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PROG_WR,
      S_PROG_WT,
      S_SETUP_WR,
      S_ERASE_WR,
      S_PULSE,
      S_VFY_WR,
      S_VFY_RD,
      S_VFY_CHK,
      S_EXIT_WR,
      S_FAILED
   } seq_state_e;

   localparam logic [7:0] CMD_ERASE   = 8'h20;
   localparam logic [7:0] CMD_VERIFY  = 8'hA0;
   localparam logic [7:0] BYTE_ZERO   = 8'h00;
   localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/bes_addr_walker.sv
module bes_addr_walker #(
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] addr,
   output logic          last
);

   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) addr <= '0;
      else if (inc)      addr <= addr + 1'b1;
   end

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign last = &addr;
      end else begin : g_cmp
         assign last = (addr == LAST_ADDR);
      end
   endgenerate

   // R5
   walk_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !last);

endmodule

// File: rtl/bes_down_timer.sv
module bes_down_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expire
);

   logic [W-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n)               count <= '0;
      else if (load)            count <= (load_val == '0) ? W'(1) : load_val;
      else if (count != '0)     count <= count - 1'b1;
   end

   assign expire = (count <= W'(1));

   // R4
   tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(!load) && $past(count) > W'(1)) |-> (count == $past(count) - 1'b1));

endmodule

// File: rtl/bes_retry_counter.sv
module bes_retry_counter #(
   parameter int MAX_PULSES = 1000,
   localparam int CW = $clog2(MAX_PULSES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);

   localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

   logic [CW-1:0] used;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)              used <= '0;
      else if (inc && used != LIMIT)  used <= used + 1'b1;
   end

   assign at_limit = (used == LIMIT);

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      used <= LIMIT);

endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq
   import bes_pkg::*;
#(
   parameter int          DEPTH      = 16,
   parameter int          PULSE_W    = 16,
   parameter int          PROG_WAIT  = 4,
   parameter int          MAX_PULSES = 1000,
   parameter logic [7:0]  EXIT_CMD   = 8'h00,
   localparam int         AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PULSE_W-1:0] pulse_cycles,
   output logic               fl_wr_en,
   output logic [AW-1:0]      fl_wr_addr,
   output logic [7:0]         fl_wr_data,
   output logic               fl_rd_en,
   output logic [AW-1:0]      fl_rd_addr,
   input  logic [7:0]         fl_rd_data,
   output logic               busy,
   output logic               done,
   output logic               fail
);

   localparam logic [PULSE_W-1:0] PROG_WAIT_L = PULSE_W'(PROG_WAIT);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bulk_erase_seq: DEPTH must be at least 2");
      end
      if (MAX_PULSES < 1) begin : g_bad_retry
         $error("bulk_erase_seq: MAX_PULSES must be at least 1");
      end
      if (PROG_WAIT < 0 || PROG_WAIT >= (1 << PULSE_W)) begin : g_bad_wait
         $error("bulk_erase_seq: PROG_WAIT must fit in PULSE_W bits");
      end
   endgenerate

   seq_state_e        state, state_nx;
   logic [PULSE_W-1:0] pulse_lat;
   logic              go;
   logic              walk_clr, walk_inc, walk_last;
   logic [AW-1:0]     walk_addr;
   logic              tmr_load, tmr_expire;
   logic [PULSE_W-1:0] tmr_val;
   logic              rty_clr, rty_inc, rty_limit;
   logic              byte_ok;

   assign go      = start && (state == S_IDLE || state == S_FAILED);
   assign byte_ok = (fl_rd_data == BYTE_ERASED);

   bes_addr_walker #(.DEPTH(DEPTH)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (walk_clr),
      .inc   (walk_inc),
      .addr  (walk_addr),
      .last  (walk_last)
   );

   bes_down_timer #(.W(PULSE_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   bes_retry_counter #(.MAX_PULSES(MAX_PULSES)) u_rty (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rty_clr),
      .inc      (rty_inc),
      .at_limit (rty_limit)
   );

   always_comb begin
      state_nx = state;
      walk_clr = 1'b0;
      walk_inc = 1'b0;
      rty_clr  = go;
      rty_inc  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = pulse_lat;
      unique case (state)
         S_IDLE, S_FAILED: begin
            if (go) begin
               state_nx = S_PROG_WR;
               walk_clr = 1'b1;
            end
         end
         S_PROG_WR: begin
            tmr_load = 1'b1;
            tmr_val  = PROG_WAIT_L;
            state_nx = S_PROG_WT;
         end
         S_PROG_WT: begin
            if (tmr_expire) begin
               if (walk_last) begin
                  walk_clr = 1'b1;
                  state_nx = S_SETUP_WR;
               end else begin
                  walk_inc = 1'b1;
                  state_nx = S_PROG_WR;
               end
            end
         end
         S_SETUP_WR: state_nx = S_ERASE_WR;
         S_ERASE_WR: begin
            tmr_load = 1'b1;
            rty_inc  = 1'b1;
            state_nx = S_PULSE;
         end
         S_PULSE: begin
            if (tmr_expire) state_nx = S_VFY_WR;
         end
         S_VFY_WR: state_nx = S_VFY_RD;
         S_VFY_RD: state_nx = S_VFY_CHK;
         S_VFY_CHK: begin
            if (byte_ok) begin
               if (walk_last) begin
                  state_nx = S_EXIT_WR;
               end else begin
                  walk_inc = 1'b1;
                  state_nx = S_VFY_WR;
               end
            end else if (rty_limit) begin
               state_nx = S_FAILED;
            end else begin
               state_nx = S_SETUP_WR;
            end
         end
         S_EXIT_WR: state_nx = S_IDLE;
         default:   state_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         pulse_lat <= '0;
         done      <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= (state == S_EXIT_WR);
         if (go) pulse_lat <= pulse_cycles;
      end
   end

   always_comb begin
      fl_wr_en   = 1'b0;
      fl_wr_addr = '0;
      fl_wr_data = BYTE_ZERO;
      unique case (state)
         S_PROG_WR: begin
            fl_wr_en   = 1'b1;
            fl_wr_addr = walk_addr;
            fl_wr_data = BYTE_ZERO;
         end
         S_SETUP_WR, S_ERASE_WR: begin
            fl_wr_en   = 1'b1;
            fl_wr_data = CMD_ERASE;
         end
         S_VFY_WR: begin
            fl_wr_en   = 1'b1;
            fl_wr_addr = walk_addr;
            fl_wr_data = CMD_VERIFY;
         end
         S_EXIT_WR: begin
            fl_wr_en   = 1'b1;
            fl_wr_data = EXIT_CMD;
         end
         default: ;
      endcase
   end

   assign fl_rd_en   = (state == S_VFY_RD);
   assign fl_rd_addr = walk_addr;
   assign busy       = (state != S_IDLE) && (state != S_FAILED);
   assign fail       = (state == S_FAILED);

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done, fail}));

   // R5
   rd_after_vfy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd_en |-> $past(fl_wr_en && fl_wr_data == CMD_VERIFY && fl_wr_addr == fl_rd_addr));

   // R8
   fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!fl_wr_en && !fl_rd_en));

   // R7
   done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fl_wr_en && fl_wr_data == EXIT_CMD && fl_wr_addr == '0));

   // R5
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_wr_en && fl_rd_en));

endmodule

// File: tb/bulk_erase_seq_test.sv
module bulk_erase_seq_test;

   localparam int DEPTH = 16;
   localparam int PW    = 3;
   localparam int MAXP  = 6;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   pulse_cycles = '0;
   logic          fl_wr_en, fl_rd_en;
   logic [AW-1:0] fl_wr_addr, fl_rd_addr;
   logic [7:0]    fl_wr_data;
   logic [7:0]    fl_rd_data = '0;
   logic          busy, done, fail;

   always #2 clk = ~clk;

   bulk_erase_seq #(
      .DEPTH(DEPTH), .PULSE_W(16), .PROG_WAIT(PW), .MAX_PULSES(MAXP), .EXIT_CMD(8'h00)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pulse_cycles(pulse_cycles),
      .fl_wr_en(fl_wr_en), .fl_wr_addr(fl_wr_addr), .fl_wr_data(fl_wr_data),
      .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
      .busy(busy), .done(done), .fail(fail)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int need [DEPTH];

   // flash model: byte i reads FFh once need[i] erase pulses have been applied
   int fm_pulses = 0;
   bit fm_armed = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (fl_wr_en) begin
         if (fl_wr_data == 8'h20) begin
            if (fm_armed) begin fm_pulses = fm_pulses + 1; fm_armed = 0; end
            else fm_armed = 1;
         end else fm_armed = 0;
      end
      if (fl_rd_en)
         fl_rd_data <= (fm_pulses >= need[fl_rd_addr]) ? 8'hFF : 8'h5A;
   end

   // bus monitor
   bit mon_on = 0;
   int ph, prog_idx, last_prog, setup_cyc, erase_cyc, vfy_next, rd_cyc, rd_addr, exit_cyc;
   bit pend_setup, after_erase, first_done, exp_erase;
   int pulses_seen, verifies, done_cnt, extra;
   int e2, e3, e4, e5, e6, e7;
   int cur_p;

   always @(negedge clk) if (mon_on) begin
      if (fl_wr_en) begin
         if (fail || ph == 2) extra++;
         else if (ph == 0) begin
            if (fl_wr_data == 8'h00) begin
               if (int'(fl_wr_addr) != prog_idx) e2++;
               if (prog_idx > 0 && cyc - last_prog != PW + 1) e2++;
               prog_idx++; last_prog = cyc;
            end else if (fl_wr_data == 8'h20) begin
               if (prog_idx != DEPTH) e2++;
               if (cyc - last_prog != PW + 1) e2++;
               ph = 1; pend_setup = 1; setup_cyc = cyc;
               if (fl_wr_addr != 0) e3++;
            end else e2++;
         end else begin
            if (fl_wr_data == 8'h20) begin
               if (fl_wr_addr != 0) e3++;
               if (pend_setup) begin
                  if (cyc != setup_cyc + 1) e3++;
                  pend_setup = 0; after_erase = 1; erase_cyc = cyc; pulses_seen++;
               end else begin
                  pend_setup = 1; setup_cyc = cyc;
                  if (!exp_erase) e6++;
                  exp_erase = 0;
               end
            end else if (pend_setup) begin
               e3++; pend_setup = 0;
            end else if (fl_wr_data == 8'hA0) begin
               if (after_erase) begin
                  if (cyc - erase_cyc != ((cur_p < 1) ? 1 : cur_p) + 1) e4++;
                  if (int'(fl_wr_addr) != vfy_next) e6++;
                  after_erase = 0; first_done = 1;
               end else if (int'(fl_wr_addr) != vfy_next || exp_erase) e5++;
               verifies++; rd_cyc = cyc + 1; rd_addr = int'(fl_wr_addr);
            end else if (fl_wr_data == 8'h00) begin
               ph = 2; exit_cyc = cyc;
               if (vfy_next != DEPTH || fl_wr_addr != 0) e7++;
            end else e5++;
         end
      end
      if (fl_rd_en) begin
         if (cyc != rd_cyc || int'(fl_rd_addr) != rd_addr) e5++;
         if (fm_pulses >= need[fl_rd_addr]) vfy_next = int'(fl_rd_addr) + 1;
         else exp_erase = 1;
      end
      if (done) begin
         done_cnt++;
         if (cyc != exit_cyc + 1) e7++;
      end
   end

   task automatic check(string req, bit ok, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected pulses / checks / fail for the current need[] under resume-at-failure
   function automatic void model(output int p, output int v, output bit f);
      int i;
      p = 1; v = 0; f = 0; i = 0;
      while (i < DEPTH) begin
         v++;
         if (p >= need[i]) i++;
         else if (p == MAXP) begin f = 1; break; end
         else p++;
      end
   endfunction

   task automatic run(string name, int p, int inject);
      int xp, xv;
      bit xf;
      model(xp, xv, xf);
      @(negedge clk);
      ph = 0; prog_idx = 0; last_prog = 0; vfy_next = 0; rd_cyc = -1; exit_cyc = -10;
      pend_setup = 0; after_erase = 0; first_done = 0; exp_erase = 0;
      pulses_seen = 0; verifies = 0; done_cnt = 0; extra = 0;
      e2 = 0; e3 = 0; e4 = 0; e5 = 0; e6 = 0; e7 = 0;
      fm_pulses = 0; fm_armed = 0; cur_p = p;
      pulse_cycles = 16'(p); start = 1'b1; mon_on = 1;
      @(negedge clk);
      start = 1'b0;
      check({name, " R10 busy after start"}, busy == 1'b1, busy, 1);
      check({name, " R8 fail cleared by start"}, fail == 1'b0, fail, 0);
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (k == inject) begin start = 1'b1; pulse_cycles = 16'd2; end
         else start = 1'b0;
         if (done || fail) break;
      end
      start = 1'b0;
      repeat (12) @(negedge clk);
      check({name, " R2 preprogram"}, e2 == 0 && prog_idx == DEPTH, prog_idx, DEPTH);
      check({name, " R3 erase pair"}, e3 == 0, e3, 0);
      check({name, " R4 pulse gap"}, e4 == 0, e4, 0);
      check({name, " R5 byte checks"}, e5 == 0 && verifies == xv, verifies, xv);
      check({name, " R6 resume/pulses"}, e6 == 0 && pulses_seen == xp, pulses_seen, xp);
      check({name, " R7 done pulse"}, e7 == 0 && done_cnt == (xf ? 0 : 1), done_cnt, xf ? 0 : 1);
      check({name, " R8 fail state"}, fail == xf, fail, xf);
      check({name, " R9/R8 no extra access"}, extra == 0, extra, 0);
      check({name, " R10 idle at end"}, busy == 1'b0, busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < DEPTH; i++) need[i] = 1;
      repeat (3) @(negedge clk);
      check("R1 reset busy", busy == 0, busy, 0);
      check("R1 reset flags", done == 0 && fail == 0, {done, fail}, 0);
      check("R1 reset bus", fl_wr_en == 0 && fl_rd_en == 0, {fl_wr_en, fl_rd_en}, 0);
      @(negedge clk) rst_n = 1'b1;
      check("R1 after release", !busy && !done && !fail && !fl_wr_en, busy, 0);

      run("clean P=0", 0, -1);
      for (int s = 0; s < 4; s++) begin
         for (int i = 0; i < DEPTH; i++) need[i] = 1 + int'($urandom % 4);
         run("random", int'($urandom % 12), -1);
      end
      for (int i = 0; i < DEPTH; i++) need[i] = 1;
      need[DEPTH-1] = 3;
      run("last byte stubborn", 5, -1);
      for (int i = 0; i < DEPTH; i++) need[i] = 1;
      need[5] = MAXP + 1;
      run("budget exceeded", 1, -1);
      repeat (5) @(negedge clk);
      check("R8 fail held", fail == 1 && busy == 0, fail, 1);
      for (int i = 0; i < DEPTH; i++) need[i] = (i == 9) ? 2 : 1;
      run("start while busy", 7, 40);
      need[0] = MAXP;
      run("first byte at budget", 2, -1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule